// File: doc/BRIEF.md
# Masked General Purpose I/O Port

This block is a 32-pin general purpose I/O port that software controls through a simple register bus with per-byte lane enables. Every pin has a direction bit, and an output register holds the value driven to the pads. That register can be written whole, or single bits can be raised or lowered through separate set and clear strobes, so that several pins change in one bus write without a read-modify-write. A protection mask keeps chosen bits out of reach: they cannot be altered through the value, set or clear addresses, and they read back as zero from the value and pin views.

The pads drive the live pin levels back in. These pass through a two-flop synchronizer before software can read them, so the pin view never samples a metastable level. The block hands an output-enable vector and an output-value vector to the pad logic. Pin muxing, pull control and edge interrupts sit elsewhere.

Top module: `mgpio_port`

## Requirements
- R1: A synchronous active-low reset clears direction, output value and mask to zero. `oe_o` and `out_o` are then all zero and every pin is an input.
- R2: Bit n of `oe_o` equals direction bit n (1 = output, 0 = input). The direction register is at address 0 and reads back as written. `oe_o` does not change in a cycle with no direction write.
- R3: A write to address 4 (set) makes 1 every output bit whose written bit is 1, in enabled lanes and in unprotected positions. No output bit goes from 1 to 0.
- R4: A write to address 5 (clear) makes 0 every output bit whose written bit is 1, in enabled lanes and in unprotected positions. No output bit goes from 0 to 1.
- R5: A full-word write to address 3 (value) updates all unprotected output bits together, visible on `out_o` after the write edge.
- R6: The mask register is at address 1 and uses 1 = protected. Writes to value, set and clear never change a protected bit of the output register.
- R7: Reads of address 2 (pin view) and address 3 (value) return 0 in protected bit positions. The protected output bits keep their values and show again once unmasked.
- R8: `bus_be[k]` enables byte lane k (bits 8k+7 to 8k). Only enabled lanes are written, on every register, so 8-, 16- and 32-bit accesses all work.
- R9: A level on `pins_i` that is present before a clock edge becomes visible at address 2 after the second edge, and not after the first.
- R10: Reads of the set and clear addresses return 0. Address 3 returns the output register and not the pins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address: 0 dir, 1 mask, 2 pins, 3 value, 4 set, 5 clear |
| bus_be | input | 4 | Byte lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when no read |
| pins_i | input | 32 | Live pad levels |
| oe_o | output | 32 | Output enable per pin |
| out_o | output | 32 | Output value per pin |

## Verification
Two things can happen in the same cycle: a pin transition entering the synchronizer and a bus write to the value register. The bench changes `pins_i` on the same edge that writes a different pattern to address 3. It then checks that `out_o` and a value read return the written pattern, and that two edges later the pin view returns the new pad level. The bench also writes while the mask is active. It checks that the protected output bits survive and read as zero, and that they reappear once the mask is cleared.

// File: rtl/mgpio_pkg.sv
// Package: shared register selector for the masked GPIO port.
// Assumes a word-addressed register bus with a 3-bit address.
package mgpio_pkg;
    typedef enum logic [2:0] {
        REG_DIR  = 3'd0,
        REG_MASK = 3'd1,
        REG_PIN  = 3'd2,
        REG_OUT  = 3'd3,
        REG_SET  = 3'd4,
        REG_CLR  = 3'd5
    } reg_sel_e;
endpackage

// File: rtl/mgpio_lane_expand.sv
// Module: widens byte lane enables into a per-bit write mask.
// Assumes WIDTH is a multiple of 8.
module mgpio_lane_expand #(
    parameter int WIDTH = 32,
    localparam int LANES = WIDTH / 8
) (
    input  logic [LANES-1:0] lane_en,
    output logic [WIDTH-1:0] bit_en
);
    // One byte of enable bits per lane
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign bit_en[g*8 +: 8] = {8{lane_en[g]}};
    end
endmodule

// File: rtl/mgpio_sync.sv
// Module: multi-flop synchronizer for the asynchronous pad levels.
// Assumes each bit is independent (no multi-bit coherency needed).
module mgpio_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    // Shift the pad levels through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/mgpio_regs.sv
// Module: direction, mask and output value registers with lane and
// mask gating. Assumes at most one bus write per cycle.
module mgpio_regs
    import mgpio_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_sel_e         sel,
    input  logic [WIDTH-1:0] lane_bits,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] mask_q,
    output logic [WIDTH-1:0] out_q
);
    logic [WIDTH-1:0] open_bits;

    // Bits a value/set/clear write may touch: enabled lane and unprotected
    always_comb open_bits = lane_bits & ~mask_q;

    // Direction register, byte-lane merged
    always_ff @(posedge clk) begin
        if (!rst_n) dir_q <= '0;
        else if (wr_en && sel == REG_DIR)
            dir_q <= (dir_q & ~lane_bits) | (wdata & lane_bits);
    end

    // Mask register, byte-lane merged
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else if (wr_en && sel == REG_MASK)
            mask_q <= (mask_q & ~lane_bits) | (wdata & lane_bits);
    end

    // Output value: whole write, set strobe or clear strobe
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else if (wr_en) begin
            case (sel)
                REG_OUT: out_q <= (out_q & ~open_bits) | (wdata & open_bits);
                REG_SET: out_q <= out_q | (wdata & open_bits);
                REG_CLR: out_q <= out_q & ~(wdata & open_bits);
                default: out_q <= out_q;
            endcase
        end
    end
endmodule

// File: rtl/mgpio_port.sv
// Module: top of the masked GPIO port. Decodes the register bus,
// drives pad enables/values and returns read data combinationally.
// Assumes pins_i is asynchronous to clk.
module mgpio_port
    import mgpio_pkg::*;
#(
    parameter int WIDTH       = 32,
    parameter int SYNC_STAGES = 2,
    localparam int LANES = WIDTH / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [2:0]       bus_addr,
    input  logic [LANES-1:0] bus_be,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    input  logic [WIDTH-1:0] pins_i,
    output logic [WIDTH-1:0] oe_o,
    output logic [WIDTH-1:0] out_o
);
    reg_sel_e         sel;
    logic [WIDTH-1:0] lane_bits;
    logic [WIDTH-1:0] dir_q, mask_q, out_q, pin_q;
    logic             wr_en;

    // Decode the access
    always_comb begin
        sel   = reg_sel_e'(bus_addr);
        wr_en = bus_sel && bus_wr;
    end

    mgpio_lane_expand #(.WIDTH(WIDTH)) lane_i (
        .lane_en (bus_be),
        .bit_en  (lane_bits)
    );

    mgpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) sync_i (
        .clk (clk),
        .rst_n (rst_n),
        .d   (pins_i),
        .q   (pin_q)
    );

    mgpio_regs #(.WIDTH(WIDTH)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .sel       (sel),
        .lane_bits (lane_bits),
        .wdata     (bus_wdata),
        .dir_q     (dir_q),
        .mask_q    (mask_q),
        .out_q     (out_q)
    );

    // Read mux; masked positions of pin and value views read as zero
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (sel)
                REG_DIR:  bus_rdata = dir_q;
                REG_MASK: bus_rdata = mask_q;
                REG_PIN:  bus_rdata = pin_q & ~mask_q;
                REG_OUT:  bus_rdata = out_q & ~mask_q;
                default:  bus_rdata = '0;
            endcase
        end
    end

    // Pad outputs
    always_comb begin
        oe_o  = dir_q;
        out_o = out_q;
    end
endmodule

// File: rtl/mgpio_port_chk.sv
// Module: property checker for mgpio_port, attached with bind.
// Assumes the default 3-bit address map of mgpio_pkg.
module mgpio_port_chk
    import mgpio_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [2:0]       bus_addr,
    input logic [WIDTH-1:0] bus_rdata,
    input logic [WIDTH-1:0] oe_o,
    input logic [WIDTH-1:0] out_o,
    input logic [WIDTH-1:0] mask_q
);
    logic wr_any, wr_set, wr_clr, wr_dir, wr_outs, rd_view, rd_wo;

    always_comb begin
        wr_any  = bus_sel && bus_wr;
        wr_set  = wr_any && bus_addr == REG_SET;
        wr_clr  = wr_any && bus_addr == REG_CLR;
        wr_dir  = wr_any && bus_addr == REG_DIR;
        wr_outs = wr_any && (bus_addr == REG_OUT || wr_set || wr_clr);
        rd_view = bus_sel && !bus_wr && (bus_addr == REG_PIN || bus_addr == REG_OUT);
        rd_wo   = bus_sel && !bus_wr && (bus_addr == REG_SET || bus_addr == REG_CLR);
    end

    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> (oe_o == '0 && out_o == '0));

    a_r2_oe_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dir |=> $stable(oe_o));

    a_r3_set_never_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((~out_o & $past(out_o)) == '0));

    a_r4_clr_never_sets: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((out_o & ~$past(out_o)) == '0));

    a_r6_mask_protects: assert property (@(posedge clk) disable iff (!rst_n)
        wr_outs |=> (((out_o ^ $past(out_o)) & $past(mask_q)) == '0));

    a_r7_masked_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_view |-> ((bus_rdata & mask_q) == '0));

    a_r10_write_only_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_wo |-> (bus_rdata == '0));

    a_r5_out_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_outs |=> $stable(out_o));
endmodule

bind mgpio_port mgpio_port_chk #(.WIDTH(WIDTH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .oe_o      (oe_o),
    .out_o     (out_o),
    .mask_q    (mask_q)
);

// File: tb/mgpio_port_tb_top.sv
// Bench: table-driven register checks, then directed reset, synchronizer,
// mask-read and same-cycle pin/write tests.
module mgpio_port_tb_top;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        int          req;
        logic [2:0]  waddr;
        logic [3:0]  be;
        logic [31:0] wdata;
        logic [2:0]  raddr;
        logic [31:0] rexp;
        logic [31:0] oexp;
    } vec_t;

    // Addresses: 0 dir, 1 mask, 2 pin, 3 value, 4 set, 5 clear
    localparam vec_t TBL [12] = '{
        '{5,  3'd3, 4'hF, 32'hA5A5_F00F, 3'd3, 32'hA5A5_F00F, 32'hA5A5_F00F}, // R5
        '{3,  3'd4, 4'hF, 32'h0000_0FF0, 3'd3, 32'hA5A5_FFFF, 32'hA5A5_FFFF}, // R3
        '{4,  3'd5, 4'hF, 32'hFF00_0000, 3'd3, 32'h00A5_FFFF, 32'h00A5_FFFF}, // R4
        '{8,  3'd3, 4'h2, 32'h1234_5678, 3'd3, 32'h00A5_56FF, 32'h00A5_56FF}, // R8
        '{6,  3'd1, 4'hF, 32'hFFFF_0000, 3'd1, 32'hFFFF_0000, 32'h00A5_56FF}, // R6
        '{6,  3'd3, 4'hF, 32'h1111_2222, 3'd3, 32'h0000_2222, 32'h00A5_2222}, // R6 R7
        '{6,  3'd4, 4'hF, 32'hFFFF_0001, 3'd3, 32'h0000_2223, 32'h00A5_2223}, // R6 R3
        '{6,  3'd5, 4'hF, 32'hFFFF_0003, 3'd3, 32'h0000_2220, 32'h00A5_2220}, // R6 R4
        '{7,  3'd1, 4'hC, 32'h0000_0000, 3'd3, 32'h00A5_2220, 32'h00A5_2220}, // R7 R8
        '{2,  3'd0, 4'h5, 32'hFFFF_FFFF, 3'd0, 32'h00FF_00FF, 32'h00A5_2220}, // R2 R8
        '{10, 3'd4, 4'h8, 32'hFFFF_FFFF, 3'd4, 32'h0000_0000, 32'hFFA5_2220}, // R10
        '{4,  3'd5, 4'h1, 32'hFFFF_FFFF, 3'd3, 32'hFFA5_2200, 32'hFFA5_2200}  // R4 R8
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0, bus_rdata, pins_i = '0, oe_o, out_o;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mgpio_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pins_i(pins_i), .oe_o(oe_o), .out_o(out_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        check("R1 oe_o", oe_o, 32'h0);
        check("R1 out_o", out_o, 32'h0);
        rd(3'd0, v); check("R1 dir", v, 32'h0);
        rd(3'd1, v); check("R1 mask", v, 32'h0);
        rd(3'd3, v); check("R1 value", v, 32'h0);

        // Table walk
        foreach (TBL[i]) begin
            wr(TBL[i].waddr, TBL[i].be, TBL[i].wdata);
            check($sformatf("R%0d out_o row %0d", TBL[i].req, i), out_o, TBL[i].oexp);
            rd(TBL[i].raddr, v);
            check($sformatf("R%0d read row %0d", TBL[i].req, i), v, TBL[i].rexp);
        end
        check("R2 oe_o follows dir", oe_o, 32'h00FF_00FF);
        rd(3'd5, v); check("R10 clear reads zero", v, 32'h0);
        rd(3'd2, v); check("R10 pin view differs from value", v, 32'h0);

        // R9: two-stage synchronizer latency
        @(negedge clk) pins_i = 32'hABCD_1234;
        rd(3'd2, v); check("R9 one edge still old", v, 32'h0);
        rd(3'd2, v); check("R9 two edges new", v, 32'hABCD_1234);

        // R7: masked pin-view read
        wr(3'd1, 4'hF, 32'h0000_FFFF);
        rd(3'd2, v); check("R7 pin view masked", v, 32'hABCD_0000);
        wr(3'd1, 4'hF, 32'h0);

        // Same cycle: pin transition and full value write (R5 R9)
        @(negedge clk);
        pins_i = 32'h0F0F_0F0F;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'd3; bus_be = 4'hF; bus_wdata = 32'h3C3C_3C3C;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        check("R5 out_o same-cycle write", out_o, 32'h3C3C_3C3C);
        rd(3'd3, v); check("R10 value read not pins", v, 32'h3C3C_3C3C);
        rd(3'd2, v); check("R9 pins after concurrent write", v, 32'h0F0F_0F0F);

        // R6: fully masked port ignores set/clear/value writes
        wr(3'd1, 4'hF, 32'hFFFF_FFFF);
        wr(3'd4, 4'hF, 32'hFFFF_FFFF);
        check("R6 set ignored", out_o, 32'h3C3C_3C3C);
        wr(3'd3, 4'hF, 32'h0);
        check("R6 value ignored", out_o, 32'h3C3C_3C3C);
        rd(3'd3, v); check("R7 fully masked read", v, 32'h0);

        // R1: reset again clears everything
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        check("R1 out_o after reset", out_o, 32'h0);
        check("R1 oe_o after reset", oe_o, 32'h0);
        rd(3'd1, v); check("R1 mask after reset", v, 32'h0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule